// File: doc/BRIEF.md
# Byte-Lane SEC-DED Protected Memory

This block is a synchronous behavioural memory of 16-bit words split into two independent byte lanes. Each lane keeps its own 13-bit codeword: 8 data bits, four Hamming check bits and one overall parity bit. A write stores only the byte lanes that are enabled, so a partial write never needs a read-modify-write. A read decodes each lane on its own, corrects a single flipped bit in the returned data and flags uncorrectable damage. The two lane results are folded into a two-flag status code.

A small controller state machine samples the command on each clock and holds one of four states. `ST_STANDBY` is entered when the chip is not selected. `ST_WRITE` is entered when select and write enable are high. `ST_READ_DRIVE` is entered on a read with output enable high and at least one byte enable high. `ST_READ_SILENT` is entered on a read with output enable low or with no byte enable high. Every state can move to any other state on the next clock, as chosen by that cycle's command. Reset forces `ST_STANDBY`. Read data and flags are registered, and the output-drive indications come from the state register. Pad tri-stating is modelled with enable outputs: an undriven byte reads as zero.

A fault-injection port XORs a mask into one stored codeword, so that correction and detection can be exercised.

Top module: `ecc_bytelane_mem`

## Requirements
- R1: Reset clears every location to data 0 with a valid codeword, drives no data and no flags, and sets the state to `ST_STANDBY`.
- R2: A write cycle (cs=1, we=1) stores `wdata[7:0]` when `be[0]`=1 and stores `wdata[15:8]` when `be[1]`=1. A lane whose enable is 0 keeps its stored byte and check bits.
- R3: A read cycle (cs=1, we=0, oe=1, be≠0) makes `lane_drive` equal to the sampled `be` one clock later. `rdata` carries the corrected byte on each driven lane and zero on each undriven lane, and `err_drive`=1.
- R4: A read cycle with oe=0 or be=00 drives nothing on the next clock: `lane_drive`=00, `rdata`=0, `err_drive`=0, and both flags are 0.
- R5: During a write cycle no data and no flags are driven on the next clock, even with oe=1.
- R6: With cs=0 nothing is written and nothing is driven on the next clock.
- R7: A single flipped bit in a lane's codeword, including the overall parity bit, returns the original byte with code `{err_single,err_multi}`=10.
- R8: Two flipped bits in one lane give code 01, and the data is to be treated as invalid.
- R9: A corrected single-bit error in one lane together with a double-bit error in the other lane gives code 11.
- R10: The flags take into account only the lanes whose byte enable was 1 in the read. An error in a lane that is not enabled sets no flag.
- R11: A read does not repair the stored codeword. A repeated read reports the same error again.
- R12: When `inj_en`=1, the codeword of lane `inj_lane` (0 = low byte) at `inj_addr` is XORed with `inj_mask`. Bit 0 of the codeword is the overall parity bit. Bits 1 to 12 are Hamming positions, with check bits at positions 1, 2, 4 and 8. A write to the same lane and address in the same cycle takes priority over the injection. A later full write restores a clean codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| we | input | 1 | Write enable, active high |
| oe | input | 1 | Output enable, active high |
| be | input | 2 | Byte enables; bit 0 low byte, bit 1 high byte |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| inj_en | input | 1 | Fault-injection strobe |
| inj_lane | input | 1 | Lane to corrupt (0 low, 1 high) |
| inj_addr | input | ADDR_W | Address to corrupt |
| inj_mask | input | 13 | Codeword bits to flip |
| rdata | output | 16 | Registered corrected read data, zero on undriven lanes |
| lane_drive | output | 2 | Per-lane output-valid indication |
| err_drive | output | 1 | Flags are valid this cycle |
| err_single | output | 1 | Single-bit error corrected in an enabled lane |
| err_multi | output | 1 | Multi-bit error detected in an enabled lane |

## Verification
A table of commands mixes full-word, low-only, high-only and empty byte-enable patterns with output enable on and off. This separates lane gating from output gating, and write-cycle silence from standby silence. Every one of the 13 codeword positions is flipped alone in turn, which separates data-bit correction from check-bit and parity-bit repair. All 78 two-bit pairs are flipped in turn to confirm that a double error is never passed as a correction. Mixed faults across the lanes, read under each byte-enable pattern, show that the shared flag code combines only the lanes that were read.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;

    localparam int LANE_BITS = 8;
    localparam int CW_BITS   = 13;
    localparam int LANES     = 2;

    typedef enum logic [1:0] {
        ST_STANDBY     = 2'd0,
        ST_WRITE       = 2'd1,
        ST_READ_SILENT = 2'd2,
        ST_READ_DRIVE  = 2'd3
    } mem_state_t;

    typedef struct packed {
        logic [LANE_BITS-1:0] data;
        logic                 single;
        logic                 multi;
    } lane_dec_t;

    function automatic logic is_pow2(input int p);
        return ((p & (p - 1)) == 0);
    endfunction

    function automatic logic [CW_BITS-1:0] secded_enc(input logic [LANE_BITS-1:0] d);
        logic [CW_BITS-1:0] cw;
        int k;
        cw = '0;
        k  = 0;
        for (int p = 1; p < CW_BITS; p++) begin
            if (!is_pow2(p)) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 4; b++) begin
            for (int p = 1; p < CW_BITS; p++) begin
                if (!is_pow2(p) && ((p >> b) & 1) == 1) begin
                    cw[1 << b] = cw[1 << b] ^ cw[p];
                end
            end
        end
        cw[0] = ^cw[CW_BITS-1:1];
        return cw;
    endfunction

    function automatic lane_dec_t secded_dec(input logic [CW_BITS-1:0] cw);
        logic [3:0]         syn;
        logic               odd;
        logic [CW_BITS-1:0] fix;
        lane_dec_t          r;
        int                 k;
        syn = '0;
        for (int p = 1; p < CW_BITS; p++) begin
            if (cw[p]) syn = syn ^ 4'(p);
        end
        odd = ^cw;
        fix = cw;
        r   = '0;
        if (odd) begin
            if (syn == 4'd0) begin
                r.single = 1'b1;
            end else if (int'(syn) < CW_BITS) begin
                fix[syn] = ~fix[syn];
                r.single = 1'b1;
            end else begin
                r.multi = 1'b1;
            end
        end else if (syn != 4'd0) begin
            r.multi = 1'b1;
        end
        k = 0;
        for (int p = 1; p < CW_BITS; p++) begin
            if (!is_pow2(p)) begin
                r.data[k] = fix[p];
                k++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ecc_lane.sv
module ecc_lane
    import ecc_mem_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [LANE_BITS-1:0] wbyte,
    input  logic                 inj_en,
    input  logic [ADDR_W-1:0]    inj_addr,
    input  logic [CW_BITS-1:0]   inj_mask,
    output logic [LANE_BITS-1:0] rbyte,
    output logic                 single,
    output logic                 multi
);

    logic [CW_BITS-1:0] store [DEPTH];
    lane_dec_t          dec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                store[i] <= '0;
            end
        end else begin
            if (inj_en) begin
                store[inj_addr] <= store[inj_addr] ^ inj_mask;
            end
            if (wr_en) begin
                store[addr] <= secded_enc(wbyte);
            end
        end
    end

    always_comb begin
        dec    = secded_dec(store[addr]);
        rbyte  = dec.data;
        single = dec.single;
        multi  = dec.multi;
    end

    // R7 R8: one lane never reports both a correction and a detection
    assert_lane_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(single && multi));

    // R2: a clean write reads back unchanged with no error at the same address
    assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inj_en) |=> ((addr != $past(addr)) ||
                                (!single && !multi && rbyte == $past(wbyte))));

endmodule

// File: rtl/ecc_flag_merge.sv
module ecc_flag_merge
    import ecc_mem_pkg::*;
(
    input  logic [LANES-1:0] lane_single,
    input  logic [LANES-1:0] lane_multi,
    input  logic [LANES-1:0] lane_sel,
    output logic             any_single,
    output logic             any_multi
);

    always_comb begin
        any_single = |(lane_single & lane_sel);
        any_multi  = |(lane_multi & lane_sel);
    end

endmodule

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
    import ecc_mem_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs,
    input  logic                       we,
    input  logic                       oe,
    input  logic [LANES-1:0]           be,
    input  logic [LANES*LANE_BITS-1:0] cor_data,
    input  logic                       any_single,
    input  logic                       any_multi,
    output logic [LANES*LANE_BITS-1:0] rdata,
    output logic [LANES-1:0]           lane_drive,
    output logic                       err_drive,
    output logic                       err_single,
    output logic                       err_multi
);

    mem_state_t                 state_q;
    mem_state_t                 state_d;
    logic [LANES*LANE_BITS-1:0] data_q;
    logic [LANES-1:0]           be_q;
    logic                       e1_q;
    logic                       e2_q;

    always_comb begin
        if (!cs)                     state_d = ST_STANDBY;
        else if (we)                 state_d = ST_WRITE;
        else if (oe && (be != '0))   state_d = ST_READ_DRIVE;
        else                         state_d = ST_READ_SILENT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            be_q   <= '0;
            e1_q   <= 1'b0;
            e2_q   <= 1'b0;
        end else begin
            data_q <= cor_data;
            be_q   <= be;
            e1_q   <= any_single;
            e2_q   <= any_multi;
        end
    end

    always_comb begin
        rdata      = '0;
        lane_drive = '0;
        err_drive  = 1'b0;
        err_single = 1'b0;
        err_multi  = 1'b0;
        unique case (state_q)
            ST_READ_DRIVE: begin
                lane_drive = be_q;
                err_drive  = 1'b1;
                err_single = e1_q;
                err_multi  = e2_q;
                for (int g = 0; g < LANES; g++) begin
                    if (be_q[g]) rdata[g*LANE_BITS +: LANE_BITS] = data_q[g*LANE_BITS +: LANE_BITS];
                end
            end
            ST_STANDBY, ST_WRITE, ST_READ_SILENT: begin
            end
            default: begin
            end
        endcase
    end

    assert_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we) |=> (lane_drive == '0 && !err_drive));

    assert_standby_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (lane_drive == '0 && !err_drive && rdata == '0));

    assert_read_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !we && oe) |=> (lane_drive == $past(be)));

    assert_flags_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !err_drive |-> (!err_single && !err_multi && lane_drive == '0 && rdata == '0));

    assert_mixed_needs_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_single && err_multi) |-> (lane_drive == '1));

endmodule

// File: rtl/ecc_bytelane_mem.sv
module ecc_bytelane_mem
    import ecc_mem_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs,
    input  logic                       we,
    input  logic                       oe,
    input  logic [LANES-1:0]           be,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [LANES*LANE_BITS-1:0] wdata,
    input  logic                       inj_en,
    input  logic                       inj_lane,
    input  logic [ADDR_W-1:0]          inj_addr,
    input  logic [CW_BITS-1:0]         inj_mask,
    output logic [LANES*LANE_BITS-1:0] rdata,
    output logic [LANES-1:0]           lane_drive,
    output logic                       err_drive,
    output logic                       err_single,
    output logic                       err_multi
);

    logic [LANES*LANE_BITS-1:0] cor_data;
    logic [LANES-1:0]           lane_single;
    logic [LANES-1:0]           lane_multi;
    logic                       any_single;
    logic                       any_multi;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_wr;
        logic lane_inj;
        assign lane_wr  = cs && we && be[g];
        assign lane_inj = inj_en && (inj_lane == 1'(g));
        ecc_lane #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (lane_wr),
            .addr     (addr),
            .wbyte    (wdata[g*LANE_BITS +: LANE_BITS]),
            .inj_en   (lane_inj),
            .inj_addr (inj_addr),
            .inj_mask (inj_mask),
            .rbyte    (cor_data[g*LANE_BITS +: LANE_BITS]),
            .single   (lane_single[g]),
            .multi    (lane_multi[g])
        );
    end

    ecc_flag_merge u_merge (
        .lane_single (lane_single),
        .lane_multi  (lane_multi),
        .lane_sel    (be),
        .any_single  (any_single),
        .any_multi   (any_multi)
    );

    ecc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .we         (we),
        .oe         (oe),
        .be         (be),
        .cor_data   (cor_data),
        .any_single (any_single),
        .any_multi  (any_multi),
        .rdata      (rdata),
        .lane_drive (lane_drive),
        .err_drive  (err_drive),
        .err_single (err_single),
        .err_multi  (err_multi)
    );

endmodule

// File: tb/test_ecc_bytelane_mem.sv
`timescale 1ns/1ps
module test_ecc_bytelane_mem;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs, we, oe, inj_en, inj_lane;
    logic [1:0]  be;
    logic [3:0]  addr, inj_addr;
    logic [15:0] wdata;
    logic [12:0] inj_mask;
    logic [15:0] rdata;
    logic [1:0]  lane_drive;
    logic        err_drive, err_single, err_multi;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ecc_bytelane_mem #(.DEPTH(16)) i_ecc_bytelane_mem (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .oe(oe), .be(be),
        .addr(addr), .wdata(wdata), .inj_en(inj_en), .inj_lane(inj_lane),
        .inj_addr(inj_addr), .inj_mask(inj_mask), .rdata(rdata),
        .lane_drive(lane_drive), .err_drive(err_drive),
        .err_single(err_single), .err_multi(err_multi)
    );

    // kind: 0 write, 1 read, 2 inject, 3 deselected with write-like inputs
    typedef struct packed {
        logic [1:0]  kind;
        logic        oe;
        logic [3:0]  addr;
        logic [1:0]  be;
        logic [15:0] data;
        logic        lane;
        logic [12:0] mask;
        logic        chk_data;
        logic [15:0] exp_data;
        logic [1:0]  exp_lane;
        logic        exp_fv;
        logic        exp_e1;
        logic        exp_e2;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{2'd0,1'b1,4'd1,2'b11,16'hA55A,1'b0,13'h0000,1'b1,16'h0000,2'b00,1'b0,1'b0,1'b0,4'd5},  // R5
        '{2'd1,1'b1,4'd1,2'b11,16'h0000,1'b0,13'h0000,1'b1,16'hA55A,2'b11,1'b1,1'b0,1'b0,4'd3},  // R3
        '{2'd0,1'b0,4'd1,2'b01,16'h00FF,1'b0,13'h0000,1'b1,16'h0000,2'b00,1'b0,1'b0,1'b0,4'd2},  // R2
        '{2'd1,1'b1,4'd1,2'b11,16'h0000,1'b0,13'h0000,1'b1,16'hA5FF,2'b11,1'b1,1'b0,1'b0,4'd2},  // R2
        '{2'd1,1'b1,4'd1,2'b01,16'h0000,1'b0,13'h0000,1'b1,16'h00FF,2'b01,1'b1,1'b0,1'b0,4'd3},  // R3
        '{2'd1,1'b0,4'd1,2'b11,16'h0000,1'b0,13'h0000,1'b1,16'h0000,2'b00,1'b0,1'b0,1'b0,4'd4},  // R4
        '{2'd1,1'b1,4'd1,2'b00,16'h0000,1'b0,13'h0000,1'b1,16'h0000,2'b00,1'b0,1'b0,1'b0,4'd4},  // R4
        '{2'd0,1'b0,4'd2,2'b11,16'h1234,1'b0,13'h0000,1'b1,16'h0000,2'b00,1'b0,1'b0,1'b0,4'd2},  // R2
        '{2'd2,1'b0,4'd2,2'b00,16'h0000,1'b0,13'h0020,1'b1,16'h0000,2'b00,1'b0,1'b0,1'b0,4'd12}, // R12
        '{2'd1,1'b1,4'd2,2'b11,16'h0000,1'b0,13'h0000,1'b1,16'h1234,2'b11,1'b1,1'b1,1'b0,4'd7},  // R7
        '{2'd1,1'b1,4'd2,2'b11,16'h0000,1'b0,13'h0000,1'b1,16'h1234,2'b11,1'b1,1'b1,1'b0,4'd11}, // R11
        '{2'd2,1'b0,4'd2,2'b00,16'h0000,1'b0,13'h0020,1'b1,16'h0000,2'b00,1'b0,1'b0,1'b0,4'd12}, // R12
        '{2'd1,1'b1,4'd2,2'b11,16'h0000,1'b0,13'h0000,1'b1,16'h1234,2'b11,1'b1,1'b0,1'b0,4'd12}, // R12
        '{2'd2,1'b0,4'd2,2'b00,16'h0000,1'b1,13'h0001,1'b1,16'h0000,2'b00,1'b0,1'b0,1'b0,4'd7},  // R7
        '{2'd1,1'b1,4'd2,2'b11,16'h0000,1'b0,13'h0000,1'b1,16'h1234,2'b11,1'b1,1'b1,1'b0,4'd7},  // R7
        '{2'd2,1'b0,4'd2,2'b00,16'h0000,1'b0,13'h0006,1'b1,16'h0000,2'b00,1'b0,1'b0,1'b0,4'd8},  // R8
        '{2'd1,1'b1,4'd2,2'b11,16'h0000,1'b0,13'h0000,1'b0,16'h0000,2'b11,1'b1,1'b1,1'b1,4'd9},  // R9
        '{2'd1,1'b1,4'd2,2'b01,16'h0000,1'b0,13'h0000,1'b0,16'h0000,2'b01,1'b1,1'b0,1'b1,4'd10}, // R10 R8
        '{2'd1,1'b1,4'd2,2'b10,16'h0000,1'b0,13'h0000,1'b1,16'h1200,2'b10,1'b1,1'b1,1'b0,4'd10}, // R10
        '{2'd0,1'b0,4'd2,2'b11,16'hBEEF,1'b0,13'h0000,1'b1,16'h0000,2'b00,1'b0,1'b0,1'b0,4'd2},  // R2
        '{2'd1,1'b1,4'd2,2'b11,16'h0000,1'b0,13'h0000,1'b1,16'hBEEF,2'b11,1'b1,1'b0,1'b0,4'd12}, // R12
        '{2'd3,1'b1,4'd1,2'b11,16'hFFFF,1'b0,13'h0000,1'b1,16'h0000,2'b00,1'b0,1'b0,1'b0,4'd6},  // R6
        '{2'd1,1'b1,4'd1,2'b11,16'h0000,1'b0,13'h0000,1'b1,16'hA5FF,2'b11,1'b1,1'b0,1'b0,4'd6}   // R6
    };

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic idle_inputs();
        cs = 1'b0; we = 1'b0; oe = 1'b0; be = 2'b00; addr = '0; wdata = '0;
        inj_en = 1'b0; inj_lane = 1'b0; inj_addr = '0; inj_mask = '0;
    endtask

    // Drive one command for one clock, then let outputs settle after the edge
    task automatic cycle(input logic [1:0] kind, input logic o, input logic [3:0] a,
                         input logic [1:0] b, input logic [15:0] d, input logic ln,
                         input logic [12:0] m);
        @(negedge clk);
        idle_inputs();
        case (kind)
            2'd0: begin cs = 1'b1; we = 1'b1; oe = o; be = b; addr = a; wdata = d; end
            2'd1: begin cs = 1'b1; we = 1'b0; oe = o; be = b; addr = a; end
            2'd2: begin inj_en = 1'b1; inj_lane = ln; inj_addr = a; inj_mask = m; end
            default: begin we = 1'b1; oe = o; be = b; addr = a; wdata = d; end
        endcase
        @(posedge clk);
        #1;
    endtask

    task automatic chk_out(input string req, input logic cd, input logic [15:0] ed,
                           input logic [1:0] el, input logic fv, input logic e1, input logic e2);
        if (cd) chk(req, "rdata", 32'(rdata), 32'(ed));
        chk(req, "lane_drive", 32'(lane_drive), 32'(el));
        chk(req, "err_drive", 32'(err_drive), 32'(fv));
        chk(req, "err_single", 32'(err_single), 32'(e1));
        chk(req, "err_multi", 32'(err_multi), 32'(e2));
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        do_reset();
        #1;
        // R1: outputs quiet after reset, unwritten word reads zero with no error
        chk_out("R1", 1'b1, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b0);
        cycle(2'd1, 1'b1, 4'd7, 2'b11, 16'h0, 1'b0, 13'h0);
        chk_out("R1", 1'b1, 16'h0000, 2'b11, 1'b1, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            cycle(VEC[i].kind, VEC[i].oe, VEC[i].addr, VEC[i].be, VEC[i].data, VEC[i].lane, VEC[i].mask);
            chk_out(tag, VEC[i].chk_data, VEC[i].exp_data, VEC[i].exp_lane,
                    VEC[i].exp_fv, VEC[i].exp_e1, VEC[i].exp_e2);
        end

        // R7: every single codeword position of the high lane is corrected
        cycle(2'd0, 1'b0, 4'd4, 2'b11, 16'h5AC3, 1'b0, 13'h0);
        for (int b = 0; b < 13; b++) begin
            cycle(2'd2, 1'b0, 4'd4, 2'b00, 16'h0, 1'b1, 13'(1 << b));
            cycle(2'd1, 1'b1, 4'd4, 2'b11, 16'h0, 1'b0, 13'h0);
            chk_out("R7", 1'b1, 16'h5AC3, 2'b11, 1'b1, 1'b1, 1'b0);
            cycle(2'd2, 1'b0, 4'd4, 2'b00, 16'h0, 1'b1, 13'(1 << b));
        end

        // R8: every two-bit pair in the low lane is detected, never corrected
        for (int b0 = 0; b0 < 13; b0++) begin
            for (int b1 = b0 + 1; b1 < 13; b1++) begin
                cycle(2'd2, 1'b0, 4'd4, 2'b00, 16'h0, 1'b0, 13'((1 << b0) | (1 << b1)));
                cycle(2'd1, 1'b1, 4'd4, 2'b01, 16'h0, 1'b0, 13'h0);
                chk_out("R8", 1'b0, 16'h0, 2'b01, 1'b1, 1'b0, 1'b1);
                cycle(2'd2, 1'b0, 4'd4, 2'b00, 16'h0, 1'b0, 13'((1 << b0) | (1 << b1)));
            end
        end
        cycle(2'd1, 1'b1, 4'd4, 2'b11, 16'h0, 1'b0, 13'h0);
        chk_out("R11", 1'b1, 16'h5AC3, 2'b11, 1'b1, 1'b0, 1'b0);

        // R12: a write to the same lane and address outranks a simultaneous injection
        @(negedge clk);
        idle_inputs();
        cs = 1'b1; we = 1'b1; be = 2'b10; addr = 4'd3; wdata = 16'h7700;
        inj_en = 1'b1; inj_lane = 1'b1; inj_addr = 4'd3; inj_mask = 13'h0008;
        @(posedge clk);
        #1;
        cycle(2'd1, 1'b1, 4'd3, 2'b11, 16'h0, 1'b0, 13'h0);
        chk_out("R12", 1'b1, 16'h7700, 2'b11, 1'b1, 1'b0, 1'b0);

        // R1: a reset in mid-run clears stored contents
        cycle(2'd0, 1'b0, 4'd9, 2'b11, 16'hCAFE, 1'b0, 13'h0);
        do_reset();
        cycle(2'd1, 1'b1, 4'd9, 2'b11, 16'h0, 1'b0, 13'h0);
        chk_out("R1", 1'b1, 16'h0000, 2'b11, 1'b1, 1'b0, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule